// File: doc/BRIEF.md
# Cascaded Decimal Stopwatch Counter

This block keeps elapsed time as eight 4-bit digit values in the form mm:ss.ffff. It runs from a 100 MHz system clock. A prescale stage counts run-enabled clock cycles and emits a one-cycle step strobe every ten thousand of them, which is once per 0.0001 s. That strobe drives a chain of modulus counters. Each stage counts from zero up to its modulus minus one and then wraps. When a stage wraps, its combinational rollover flag steps the next more significant stage in the same clock edge.

The same parameterized modulus counter is used for every digit and for the prescaler. Only its modulus and bit width change. The modulus of each digit position comes from a parameter word holding one 4-bit field per digit. In the default word, the four fraction digits and the two units digits are modulus 10, and the two tens digits are modulus 6. The prescale period is also a parameter.

Top module: `decimal_stopwatch`

## Requirements
- R1: With reset low and run held high from a cleared state, digit0 first becomes 1 after exactly TICK_CYCLES rising edges. The default TICK_CYCLES is 10000, which is 0.0001 s at 100 MHz, held in a 14-bit prescaler.
- R2: The internal step strobe is high for one cycle in each prescale period. Digit0 therefore advances by exactly one per period, never more.
- R3: While run is low, every digit holds its value and the prescaler keeps its phase. Counting resumes where it stopped once run returns high.
- R4: Reset is synchronous. A rising edge with reset high clears all eight digits and the prescaler to 0, even when run is also high.
- R5: Digit i counts 0,1,…,M(i)−1 and then wraps to 0. M(i) is the 4-bit field DIGIT_MODS[4i+3:4i]. No digit ever shows a value at or above its modulus.
- R6: A digit advances only in the cycle in which the digit below it wraps (for digit0: in the cycle the step strobe is high), and then by exactly one.
- R7: With the default DIGIT_MODS = 32'h6A6A_AAAA:
  - digits 0 to 3 are the 0.0001 s, 0.001 s, 0.01 s and 0.1 s places, each modulus 10;
  - digit4 and digit5 are seconds units (modulus 10) and tens (modulus 6);
  - digit6 and digit7 are minutes units (modulus 10) and tens (modulus 6).
- R8: After the product of all eight moduli of step strobes, every digit reads 0 again. For the default moduli this is the wrap from 59:59.9999 to 00:00.0000.
- R9: Reset also restarts the prescaler phase, so the first step after reset always comes a full TICK_CYCLES run cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 100 MHz nominal |
| reset | input | 1 | Synchronous clear of all counters, overrides run |
| run | input | 1 | Count enable for the prescaler |
| digit0 | output | 4 | 0.0001 s digit |
| digit1 | output | 4 | 0.001 s digit |
| digit2 | output | 4 | 0.01 s digit |
| digit3 | output | 4 | 0.1 s digit |
| digit4 | output | 4 | Seconds units digit |
| digit5 | output | 4 | Seconds tens digit |
| digit6 | output | 4 | Minutes units digit |
| digit7 | output | 4 | Minutes tens digit |

## Verification
The hardest case to reach from the ports is the full wrap of the chain, where every stage rolls over in one edge. At the default rate this needs an hour of modelled time. The bench therefore runs a second instance with a 3-cycle prescaler and alternating moduli of 3 and 2. That instance wraps the whole chain after 3888 run cycles and is compared against a mixed-radix model every cycle. A third instance steps once per cycle with the default moduli, so it carries into the seconds tens digit within 100000 cycles. Meanwhile the default instance confirms the exact 10000-cycle spacing of the first step.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int NUM_DIGITS = 8;
  localparam int DIGIT_W = 4;
  localparam int TICK_CYCLES_DEFAULT = 10000;
  localparam logic [NUM_DIGITS*DIGIT_W-1:0] DIGIT_MODS_DEFAULT = 32'h6A6A_AAAA;

  typedef struct packed {
    logic clear;
    logic tick;
  } swStrobes_t;
endpackage

// File: rtl/sw_mod_counter.sv
module sw_mod_counter #(
  parameter int MODULUS = 10,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             inc,
  output logic [WIDTH-1:0] count,
  output logic             rollover
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  logic atLast;
  assign atLast = (count == LAST);
  // combinational: the next stage steps on the same edge this one wraps
  assign rollover = inc && atLast;

  always_ff @(posedge clk) begin
    if (clear) begin
      count <= '0;
    end else if (inc) begin
      count <= atLast ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/sw_prescale_ctrl.sv
module sw_prescale_ctrl #(
  parameter int TICK_CYCLES = sw_pkg::TICK_CYCLES_DEFAULT
) (
  input  logic               clk,
  input  logic               reset,
  input  logic               run,
  output sw_pkg::swStrobes_t strobes
);
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [TW-1:0] unusedPhase;
  logic          tickRaw;

  sw_mod_counter #(.MODULUS(TICK_CYCLES), .WIDTH(TW)) u_prescale (
    .clk      (clk),
    .clear    (reset),
    .inc      (run),
    .count    (unusedPhase),
    .rollover (tickRaw)
  );

  assign strobes.clear = reset;
  assign strobes.tick  = tickRaw;
endmodule

// File: rtl/sw_digit_datapath.sv
module sw_digit_datapath #(
  parameter logic [sw_pkg::NUM_DIGITS*sw_pkg::DIGIT_W-1:0] DIGIT_MODS = sw_pkg::DIGIT_MODS_DEFAULT
) (
  input  logic                                         clk,
  input  sw_pkg::swStrobes_t                           strobes,
  output logic [sw_pkg::NUM_DIGITS-1:0][sw_pkg::DIGIT_W-1:0] digits
);
  localparam int N = sw_pkg::NUM_DIGITS;
  localparam int W = sw_pkg::DIGIT_W;

  logic [N-1:0] carryIn;
  logic         unusedChainWrap;

  assign carryIn[0] = strobes.tick;

  for (genvar i = 0; i < N; i++) begin : g_digit
    localparam int MOD_I = int'(DIGIT_MODS[W*i +: W]);
    logic rollOut;

    sw_mod_counter #(.MODULUS(MOD_I), .WIDTH(W)) u_digit (
      .clk      (clk),
      .clear    (strobes.clear),
      .inc      (carryIn[i]),
      .count    (digits[i]),
      .rollover (rollOut)
    );

    if (i < N - 1) begin : g_link
      assign carryIn[i+1] = rollOut;
    end else begin : g_top
      assign unusedChainWrap = rollOut;
    end
  end
endmodule

// File: rtl/decimal_stopwatch.sv
module decimal_stopwatch #(
  parameter int TICK_CYCLES = sw_pkg::TICK_CYCLES_DEFAULT,
  parameter logic [31:0] DIGIT_MODS = sw_pkg::DIGIT_MODS_DEFAULT
) (
  input  logic       clk,
  input  logic       reset,
  input  logic       run,
  output logic [3:0] digit0,
  output logic [3:0] digit1,
  output logic [3:0] digit2,
  output logic [3:0] digit3,
  output logic [3:0] digit4,
  output logic [3:0] digit5,
  output logic [3:0] digit6,
  output logic [3:0] digit7
);
  sw_pkg::swStrobes_t strobes;
  logic [sw_pkg::NUM_DIGITS-1:0][sw_pkg::DIGIT_W-1:0] digitBus;

  sw_prescale_ctrl #(.TICK_CYCLES(TICK_CYCLES)) u_ctrl (
    .clk     (clk),
    .reset   (reset),
    .run     (run),
    .strobes (strobes)
  );

  sw_digit_datapath #(.DIGIT_MODS(DIGIT_MODS)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .digits  (digitBus)
  );

  assign digit0 = digitBus[0];
  assign digit1 = digitBus[1];
  assign digit2 = digitBus[2];
  assign digit3 = digitBus[3];
  assign digit4 = digitBus[4];
  assign digit5 = digitBus[5];
  assign digit6 = digitBus[6];
  assign digit7 = digitBus[7];
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
  parameter int TICK_CYCLES = 10000,
  parameter logic [31:0] DIGIT_MODS = 32'h6A6A_AAAA
) (
  input logic             clk,
  input logic             reset,
  input logic             run,
  input logic             tick,
  input logic [7:0][3:0]  d
);
  localparam logic [3:0] M0 = DIGIT_MODS[3:0];
  localparam logic [3:0] M1 = DIGIT_MODS[7:4];

  // R2: step strobe is a single-cycle pulse when the period exceeds one cycle
  a_r2_tick_single: assert property (@(posedge clk) disable iff (reset)
    (tick && (TICK_CYCLES > 1)) |=> !tick);

  // R4: synchronous reset clears everything regardless of run
  a_r4_reset_clears: assert property (@(posedge clk)
    reset |=> (d == '0));

  // R3: run low freezes the digits
  a_r3_run_low_hold: assert property (@(posedge clk) disable iff (reset)
    !run |=> $stable(d));

  // R6: without a step strobe no digit moves
  a_r6_no_tick_hold: assert property (@(posedge clk) disable iff (reset)
    !tick |=> $stable(d));

  // R5: digit0 wraps to zero after its last value
  a_r5_low_wrap: assert property (@(posedge clk) disable iff (reset)
    (tick && d[0] == M0 - 4'd1) |=> (d[0] == 4'd0));

  // R6: carry from digit0 steps digit1 by one
  a_r6_carry_step: assert property (@(posedge clk) disable iff (reset)
    (tick && d[0] == M0 - 4'd1 && d[1] != M1 - 4'd1) |=> (d[1] == $past(d[1]) + 4'd1));

  for (genvar i = 0; i < 8; i++) begin : g_rng
    localparam logic [3:0] MI = DIGIT_MODS[4*i +: 4];
    // R5: every digit stays below its modulus
    a_r5_in_range: assert property (@(posedge clk) disable iff (reset)
      d[i] < MI);
  end
endmodule

bind decimal_stopwatch sw_checker #(.TICK_CYCLES(TICK_CYCLES), .DIGIT_MODS(DIGIT_MODS)) u_chk (
  .clk   (clk),
  .reset (reset),
  .run   (run),
  .tick  (strobes.tick),
  .d     (digitBus)
);

// File: tb/tb_decimal_stopwatch.sv
module tb_decimal_stopwatch;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  localparam int T_SMALL = 3;
  localparam logic [31:0] M_SMALL = 32'h2323_2323;
  localparam int T_DEC = 1;
  localparam logic [31:0] M_DEC = 32'h6A6A_AAAA;
  localparam int T_FULL = 10000;
  localparam logic [31:0] M_FULL = 32'h6A6A_AAAA;

  logic clk = 1'b0;
  logic reset = 1'b1;
  logic run = 1'b0;

  int checks = 0;
  int failures = 0;
  longint runCount = 0;
  int cycleCount = 0;
  bit finished = 1'b0;

  logic [3:0] dS [8];
  logic [3:0] dD [8];
  logic [3:0] dF [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  decimal_stopwatch #(.TICK_CYCLES(T_SMALL), .DIGIT_MODS(M_SMALL)) dut (
    .clk(clk), .reset(reset), .run(run),
    .digit0(dS[0]), .digit1(dS[1]), .digit2(dS[2]), .digit3(dS[3]),
    .digit4(dS[4]), .digit5(dS[5]), .digit6(dS[6]), .digit7(dS[7]));

  decimal_stopwatch #(.TICK_CYCLES(T_DEC), .DIGIT_MODS(M_DEC)) dutDec (
    .clk(clk), .reset(reset), .run(run),
    .digit0(dD[0]), .digit1(dD[1]), .digit2(dD[2]), .digit3(dD[3]),
    .digit4(dD[4]), .digit5(dD[5]), .digit6(dD[6]), .digit7(dD[7]));

  decimal_stopwatch dutFull (
    .clk(clk), .reset(reset), .run(run),
    .digit0(dF[0]), .digit1(dF[1]), .digit2(dF[2]), .digit3(dF[3]),
    .digit4(dF[4]), .digit5(dF[5]), .digit6(dF[6]), .digit7(dF[7]));

  // mixed-radix model: digit idx after (runCycles / period) steps
  function automatic int expDigit(longint runCycles, int period, logic [31:0] mods, int idx);
    longint n;
    n = runCycles / period;
    for (int k = 0; k < idx; k++) n = n / longint'(mods[4*k +: 4]);
    return int'(n % longint'(mods[4*idx +: 4]));
  endfunction

  task automatic checkOne(string tag, string name, int period, logic [31:0] mods,
                          logic [3:0] act [8]);
    bit bad;
    bad = 1'b0;
    for (int i = 0; i < 8; i++) if (int'(act[i]) != expDigit(runCount, period, mods, i)) bad = 1'b1;
    checks++;
    if (bad) begin
      failures++;
      $display("FAIL %s %s run=%0d actual=%0d%0d%0d%0d%0d%0d%0d%0d expected=%0d%0d%0d%0d%0d%0d%0d%0d",
        tag, name, runCount,
        act[7], act[6], act[5], act[4], act[3], act[2], act[1], act[0],
        expDigit(runCount, period, mods, 7), expDigit(runCount, period, mods, 6),
        expDigit(runCount, period, mods, 5), expDigit(runCount, period, mods, 4),
        expDigit(runCount, period, mods, 3), expDigit(runCount, period, mods, 2),
        expDigit(runCount, period, mods, 1), expDigit(runCount, period, mods, 0));
    end
  endtask

  task automatic checkAll(string tag);
    checkOne(tag, "dut", T_SMALL, M_SMALL, dS);
    checkOne(tag, "dutDec", T_DEC, M_DEC, dD);
    checkOne(tag, "dutFull", T_FULL, M_FULL, dF);
  endtask

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    if (reset) runCount = 0;
    else if (run) runCount++;
    @(negedge clk);
  endtask

  task automatic runChecked(int n, string tag);
    for (int k = 0; k < n; k++) begin
      cycle();
      checkAll(tag);
    end
  endtask

  task automatic tReset();
    reset = 1'b1; run = 1'b0;
    cycle(); cycle(); cycle();
    reset = 1'b0;
    checkAll("R4 reset state");
    for (int i = 0; i < 8; i++) checkVal("R4 dutFull digit zero", int'(dF[i]), 0);
  endtask

  task automatic tPrescale();
    run = 1'b1;
    runChecked(T_FULL - 1, "R1 R2 prescale");
    checkVal("R1 R9 dutFull digit0 before period", int'(dF[0]), 0);
    cycle();
    checkVal("R1 R9 dutFull digit0 at period", int'(dF[0]), 1);
    checkAll("R1 R2 first step");
  endtask

  task automatic tPause();
    logic [3:0] snap [8];
    for (int i = 0; i < 8; i++) snap[i] = dS[i];
    run = 1'b0;
    runChecked(50, "R3 run low hold");
    for (int i = 0; i < 8; i++) checkVal("R3 dut digit frozen", int'(dS[i]), int'(snap[i]));
    run = 1'b1;
    runChecked(20, "R3 resume phase");
  endtask

  task automatic tResetOverRun();
    run = 1'b1; reset = 1'b1;
    cycle(); cycle();
    checkAll("R4 reset over run");
    reset = 1'b0;
    runChecked(T_SMALL, "R9 phase restart");
  endtask

  task automatic tSmallWrap();
    run = 1'b1;
    runChecked(T_SMALL * 1296 - int'(runCount), "R5 R6 chain");
    for (int i = 0; i < 8; i++) checkVal("R8 dut full wrap to zero", int'(dS[i]), 0);
    runChecked(T_SMALL, "R8 after wrap");
  endtask

  task automatic tDecimal();
    run = 1'b1;
    runChecked(100000 - int'(runCount), "R7 decimal chain");
    checkVal("R7 dutDec seconds tens", int'(dD[5]), 1);
    checkVal("R7 dutDec seconds units", int'(dD[4]), 0);
    checkVal("R7 dutDec tenths", int'(dD[3]), 0);
    checkVal("R7 dutFull 0.001s digit", int'(dF[1]), 1);
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tPrescale();
    tPause();
    tResetOverRun();
    tSmallWrap();
    tDecimal();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > WATCHDOG_CYCLES && !finished) begin
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycleCount, WATCHDOG_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
    end
  end
endmodule